// File: doc/BRIEF.md
# Double-and-Add Point Multiplication Sequencer

This block is the control unit of an elliptic-curve point multiplier. It computes Q = k·P by scanning the scalar k from its most significant end, treating the leading bit as one so that the accumulator begins equal to P. It does not do any arithmetic. Instead it sends point-level commands to an attached point arithmetic unit and waits until each one has finished.

A run has three phases:

1. One command moves P into projective coordinates.
2. A loop walks the remaining scalar bits from the top down. Each bit produces a doubling, and a bit that is set also produces an addition.
3. One final command returns the result to affine coordinates. This is the only point at which the arithmetic unit performs a field inversion.

The host supplies the scalar, its length l in bits, a field-select bit and a start pulse. It then sees `busy` while the run is in progress, and a `done` pulse at the end. The field-select bit chooses Jacobian coordinates over a prime field or López-Dahab coordinates over a binary field. The select bit is forwarded with every command, and the command order does not depend on it.

The command port is a valid/ready channel with back-pressure:

- An offered command, and its field bit, stay unchanged until the arithmetic unit takes it with `cmd_ready`.
- The unit reports that the command has finished with a one-cycle `cmd_done` pulse.
- Only one command is outstanding at any time.

Host-side pins are plain level and pulse signals.

Top module: `scalar_mult_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy`, `done`, `err` and `cmd_valid` are all low.
- R2: Suppose `start` is sampled high while idle, with a nonzero scalar and 1 ≤ l ≤ KW. From the next cycle `busy` is high, `err` is low, and the first command offered is INIT.
- R3: Command codes are INIT=2'b00, DOUBLE=2'b01, ADD=2'b10, TO_AFFINE=2'b11. While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_field` hold their values into the next cycle.
- R4: After a command is taken (`cmd_valid && cmd_ready`), `cmd_valid` stays low until the cycle after a `cmd_done` pulse.
- R5: After INIT, scalar bits l-2 down to 0 are visited in that order. Each visited bit issues one DOUBLE, followed by one ADD only when that bit is 1. Scalar bits at index l-1 and above have no effect. An ADD always directly follows a DOUBLE.
- R6: Exactly one TO_AFFINE is issued, and it is the last command of the run. When l = 1 the sequence is INIT followed directly by TO_AFFINE.
- R7: `done` is high for exactly one cycle, namely the cycle after the `cmd_done` that completes TO_AFFINE. In that same cycle `busy` is low and `err` is low.
- R8: A start with scalar = 0, with l = 0, or with l > KW is rejected. On the next cycle `done` pulses with `err` high and `busy` low, and no command is offered. `err` stays high until the next accepted start.
- R9: `start` pulses while `busy` is high are ignored. The running sequence, and its scalar and length, are unaffected.
- R10: `cmd_field` carries the `field_sel` value captured at the accepted start on every command of that run. Later changes to `field_sel` have no effect. The command sequence is the same for both field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| scalar | input | KW | Scalar k |
| bit_len | input | LW | Scalar length l in bits, LW = $clog2(KW+1) |
| field_sel | input | 1 | 0: prime field (Jacobian), 1: binary field (López-Dahab) |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was rejected |
| cmd_valid | output | 1 | Command offered to the arithmetic unit |
| cmd_ready | input | 1 | Arithmetic unit takes the command |
| cmd_op | output | 2 | Command code (see R3) |
| cmd_field | output | 1 | Field select for the command |
| cmd_done | input | 1 | One-cycle pulse: current command finished |

## Verification
The bench uses an 8-bit scalar width. It sweeps every nonzero 8-bit scalar against every length from 1 to 8, alternating the field bit. Sweeping all lengths for each scalar separates correct bit scanning from off-by-one start indices, and shows that bits at or above l-1 are ignored. The bench plays the arithmetic unit and keeps a running integer for Q (set to 1, doubled, incremented). This running value must end at 2^(l-1) plus the low l-1 bits of k, and any wrong visiting order shows up as a wrong number.

The bench also exercises the handshake in several ways:

- It varies the ready and completion delays.
- It toggles `field_sel` during stalls.
- It pulses `start` during stalls.

These stalls expose holding errors on the command port and any start that is wrongly re-accepted. The three reject cases are each followed by a good run, which shows that `err` is cleared.

// File: rtl/sms_pkg.sv
`timescale 1ns/1ps
package sms_pkg;
  typedef enum logic [1:0] {
    OP_INIT = 2'b00,
    OP_DBL  = 2'b01,
    OP_ADD  = 2'b10,
    OP_AFF  = 2'b11
  } pt_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } seq_st_e;
endpackage

// File: rtl/sms_arg_check.sv
`timescale 1ns/1ps
// Decides whether a start request carries usable operands.
module sms_arg_check #(
  parameter int KW = 256,
  parameter int LW = $clog2(KW + 1)
) (
  input  logic [KW-1:0] scalar,
  input  logic [LW-1:0] bit_len,
  output logic          args_ok
);
  localparam logic [LW-1:0] MAX_LEN = LW'(KW);

  always_comb begin
    args_ok = (|scalar) && (bit_len != '0) && (bit_len <= MAX_LEN);
  end
endmodule

// File: rtl/sms_cursor.sv
`timescale 1ns/1ps
// Holds the captured scalar and walks the bit index downward.
module sms_cursor #(
  parameter int KW = 256,
  parameter int LW = $clog2(KW + 1),
  parameter int IW = $clog2(KW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [KW-1:0] scalar_in,
  input  logic [LW-1:0] len_in,
  input  logic          step,
  output logic          cur_bit,
  output logic          at_zero
);
  logic [KW-1:0] k_q;
  logic [IW-1:0] idx_q;
  logic [LW-1:0] first_idx;

  always_comb begin
    first_idx = (len_in >= LW'(2)) ? (len_in - LW'(2)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q   <= '0;
      idx_q <= '0;
    end else if (load) begin
      k_q   <= scalar_in;
      idx_q <= IW'(first_idx);
    end else if (step && (idx_q != '0)) begin
      idx_q <= idx_q - IW'(1);
    end
  end

  always_comb begin
    cur_bit = k_q[idx_q];
    at_zero = (idx_q == '0);
  end
endmodule

// File: rtl/scalar_mult_seq.sv
`timescale 1ns/1ps
// Left-to-right double-and-add sequencer driving a point arithmetic unit.
module scalar_mult_seq #(
  parameter int KW = 256,
  parameter int LW = $clog2(KW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [KW-1:0] scalar,
  input  logic [LW-1:0] bit_len,
  input  logic          field_sel,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic          cmd_field,
  input  logic          cmd_done
);
  import sms_pkg::*;

  localparam int IW = $clog2(KW);

  seq_st_e st_q;
  pt_op_e  op_q;
  logic    fld_q;
  logic    done_q;
  logic    err_q;
  logic    len_one_q;
  logic    args_ok;
  logic    load;
  logic    step;
  logic    cur_bit;
  logic    at_zero;
  logic    finish;

  sms_arg_check #(.KW(KW), .LW(LW)) arg_i (
    .scalar  (scalar),
    .bit_len (bit_len),
    .args_ok (args_ok)
  );

  sms_cursor #(.KW(KW), .LW(LW), .IW(IW)) cur_i (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .scalar_in (scalar),
    .len_in    (bit_len),
    .step      (step),
    .cur_bit   (cur_bit),
    .at_zero   (at_zero)
  );

  always_comb begin
    finish = (st_q == ST_WAIT) && cmd_done;
    load   = (st_q == ST_IDLE) && start && args_ok;
    step   = finish && !at_zero &&
             (((op_q == OP_DBL) && !cur_bit) || (op_q == OP_ADD));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_INIT;
      fld_q     <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      len_one_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (args_ok) begin
              st_q      <= ST_ISSUE;
              op_q      <= OP_INIT;
              fld_q     <= field_sel;
              err_q     <= 1'b0;
              len_one_q <= (bit_len == LW'(1));
            end else begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cmd_done) begin
            unique case (op_q)
              OP_INIT: begin
                st_q <= ST_ISSUE;
                op_q <= len_one_q ? OP_AFF : OP_DBL;
              end
              OP_DBL: begin
                st_q <= ST_ISSUE;
                op_q <= cur_bit ? OP_ADD : (at_zero ? OP_AFF : OP_DBL);
              end
              OP_ADD: begin
                st_q <= ST_ISSUE;
                op_q <= at_zero ? OP_AFF : OP_DBL;
              end
              OP_AFF: begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st_q != ST_IDLE);
    done      = done_q;
    err       = err_q;
    cmd_valid = (st_q == ST_ISSUE);
    cmd_op    = op_q;
    cmd_field = fld_q;
  end
endmodule

// File: rtl/sms_seq_checker.sv
`timescale 1ns/1ps
module sms_seq_checker #(
  parameter int KW = 256,
  parameter int LW = $clog2(KW + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [KW-1:0] scalar,
  input logic [LW-1:0] bit_len,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic          cmd_field,
  input logic          cmd_done
);
  logic       pend_q;
  logic [1:0] last_op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      last_op_q <= 2'b00;
    end else begin
      if (cmd_valid && cmd_ready) begin
        pend_q    <= 1'b1;
        last_op_q <= cmd_op;
      end else if (cmd_done) begin
        pend_q <= 1'b0;
      end
    end
  end

  p_init_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cmd_valid && cmd_op == 2'b00 && !err));

  p_hold_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_field)));

  p_one_out_r4: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !cmd_valid);

  p_add_after_dbl_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'b10) |-> (last_op_q == 2'b01));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !cmd_valid));

  p_reject_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (scalar == '0 || bit_len == '0)) |=> (done && err && !cmd_valid));

  p_busy_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !cmd_done) |=> busy);
endmodule

bind scalar_mult_seq sms_seq_checker #(.KW(KW), .LW(LW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .scalar(scalar), .bit_len(bit_len),
  .busy(busy), .done(done), .err(err), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_field(cmd_field),
  .cmd_done(cmd_done)
);

// File: tb/scalar_mult_seq_tb_top.sv
`timescale 1ns/1ps
module scalar_mult_seq_tb_top;
  localparam int KW = 8;
  localparam int LW = $clog2(KW + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic [LW-1:0] bit_len = '0;
  logic          field_sel = 1'b0;
  logic          busy, done, err, cmd_valid, cmd_field;
  logic          cmd_ready = 1'b0;
  logic          cmd_done = 1'b0;
  logic [1:0]    cmd_op;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  scalar_mult_seq #(.KW(KW), .LW(LW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .scalar(scalar), .bit_len(bit_len),
    .field_sel(field_sel), .busy(busy), .done(done), .err(err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_field(cmd_field), .cmd_done(cmd_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_job(input int k, input int l, input bit f);
    int exp_ops[2*KW+2];
    int got_ops[2*KW+2];
    int n_exp = 0;
    int n_got = 0;
    int q = 0;
    int exp_q;
    int bad_hold = 0;
    int bad_out = 0;
    int bad_fld = 0;
    int seq_bad = 0;
    bit fin = 0;
    exp_ops[n_exp++] = 0;
    for (int i = l - 2; i >= 0; i--) begin
      exp_ops[n_exp++] = 1;
      if (k[i]) exp_ops[n_exp++] = 2;
    end
    exp_ops[n_exp++] = 3;
    exp_q = (1 << (l - 1)) + (k & ((1 << (l - 1)) - 1));

    scalar = KW'(k); bit_len = LW'(l); field_sel = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !err, "R2", "busy after accepted start", busy, 1);

    while (!fin) begin
      int guard = 0;
      int op;
      int d = (k + l + n_got) % 3;
      while (!cmd_valid && guard < 200) begin
        @(negedge clk);
        guard++;
      end
      if (!cmd_valid) begin
        chk(0, "R6", "command timeout", n_got, n_exp);
        break;
      end
      op = int'(cmd_op);
      if (cmd_field != f) bad_fld++;
      for (int j = 0; j < d; j++) begin
        field_sel = ~f;
        start = 1'b1;
        scalar = KW'(k ^ 8'h5a);
        @(negedge clk);
        if (!cmd_valid || int'(cmd_op) != op || cmd_field != f) bad_hold++;
      end
      start = 1'b0; field_sel = f; scalar = KW'(k);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      if (n_got < 2*KW+2) got_ops[n_got] = op;
      n_got++;
      case (op)
        0: q = 1;
        1: q = q * 2;
        2: q = q + 1;
        default: ;
      endcase
      for (int w = 0; w < (k % 2); w++) begin
        if (cmd_valid) bad_out++;
        @(negedge clk);
      end
      if (cmd_valid) bad_out++;
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
      if (op == 3) begin
        fin = 1;
        chk(done && !busy && !err, "R7", "done pulse at completion", done, 1);
        @(negedge clk);
        chk(!done, "R7", "done lasts one cycle", done, 0);
      end
    end

    if (n_got != n_exp) seq_bad = 1;
    else for (int i = 0; i < n_exp; i++) if (got_ops[i] != exp_ops[i]) seq_bad = 1;
    chk(!seq_bad, "R5", "command sequence mismatch, count", n_got, n_exp);
    chk(q == exp_q, "R5", "accumulated multiple", q, exp_q);
    chk(n_got > 0 && got_ops[0] == 0, "R2", "first command INIT", n_got > 0 ? got_ops[0] : -1, 0);
    if (l == 1) chk(n_got == 2, "R6", "l=1 command count", n_got, 2);
    chk(bad_hold == 0, "R3", "command held during stall", bad_hold, 0);
    chk(bad_out == 0, "R4", "valid while outstanding", bad_out, 0);
    chk(bad_fld == 0, "R10", "field bit per command", bad_fld, 0);
    chk(bad_hold == 0 && !seq_bad, "R9", "start during busy ignored", bad_hold + seq_bad, 0);
  endtask

  task automatic run_bad(input int k, input int l);
    int vseen = 0;
    scalar = KW'(k); bit_len = LW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && err && !busy && !cmd_valid, "R8", "reject response", {done, err, busy, cmd_valid}, 4'b1100);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (cmd_valid || done || !err) vseen++;
    end
    chk(vseen == 0, "R8", "quiet and err held after reject", vseen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !cmd_valid, "R1", "outputs in reset", {busy, done, err, cmd_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !cmd_valid, "R1", "outputs after reset", {busy, done, err, cmd_valid}, 0);

    run_bad(0, 4);
    run_job(5, 3, 1'b0);
    chk(!err, "R8", "err cleared by accepted start", err, 0);
    run_bad(5, 0);
    run_job(1, 1, 1'b1);
    run_bad(5, 9);
    run_job(200, 8, 1'b1);

    for (int l = 1; l <= KW; l++) begin
      for (int k = 1; k < (1 << KW); k++) begin
        run_job(k, l, 1'((k ^ l) & 1));
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule